// File: doc/BRIEF.md
# Reset Pin Qualifier with Watchdog Reset Drive

This block sits between an active-high external reset pad and an 8-bit controller core. It samples the pad on every oscillator clock. It raises the core's internal reset only after the pad has stayed high without a break for two whole machine cycles. One machine cycle is twelve oscillator periods, so this takes 24 consecutive high samples. A single low sample throws the count away, so short glitches on the pad never reset the core.

The block also lets the pad serve as an output. A one-cycle timeout pulse from the watchdog opens a reset window of 96 oscillator periods. The internal reset is held for the whole window, and the block turns on the pad driver with a high level so that other devices on the board see the reset too. Software can turn off the pad drive with a disable bit in an auxiliary control register, which is reached through a simple register write/read port. The internal reset still follows the window when the drive is disabled.

Top module: `reset_pin_ctrl`

## Requirements
- R1: `core_rst` rises in the cycle after the 24th consecutive clock edge that samples `pin_in` high. It then stays high as long as `pin_in` keeps being sampled high.
- R2: A clock edge that samples `pin_in` low sets the qualification count back to zero. If no drive window is active, `core_rst` is low in the following cycle. Fewer than 24 consecutive high samples never raise `core_rst`.
- R3: The clock edge that samples `wdt_timeout` high opens a window. From the next cycle on, the window lasts exactly 96 cycles, unless another timeout restarts it (R4).
- R4: A timeout sampled while a window is already open restarts the window at a full 96 cycles.
- R5: `core_rst` is high during every cycle of a window, whatever the value of the disable bit.
- R6: The disable bit is bit 3 of the auxiliary register at address 8'h8E. While it is 1, `pin_oe` and `pin_out` stay low. While it is 0, both are high exactly during a window. A change to the bit takes effect in the cycle after the write edge, also in the middle of a window.
- R7: A write updates only bit 3 of address 8'h8E. Other bits of the write data, and writes to other addresses, change nothing.
- R8: `sfr_rdata` returns the disable bit at bit 3, with all other bits zero, when `sfr_addr` is 8'h8E. It returns zero for any other address.
- R9: The disable bit is cleared by power-on reset and by a pin-qualified reset, and a write is ignored in a cycle in which the pin-qualified reset is active. A watchdog window does not clear the bit.
- R10: While `por_n` is low, every output is low and the disable bit reads 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Oscillator clock |
| por_n | input | 1 | Asynchronous power-on clear, active low |
| pin_in | input | 1 | Level sampled from the reset pad |
| wdt_timeout | input | 1 | One-cycle pulse from the watchdog counter |
| sfr_wr | input | 1 | Register write strobe |
| sfr_addr | input | 8 | Register address for both write and read |
| sfr_wdata | input | 8 | Register write data |
| sfr_rdata | output | 8 | Register read data (combinational) |
| core_rst | output | 1 | Internal reset to the core |
| pin_oe | output | 1 | Pad driver enable |
| pin_out | output | 1 | Level driven onto the pad when enabled |

## Verification
The watchdog window and the register write can act on the same clock edge. The bench provokes this by pulsing `wdt_timeout` in the same cycle as a write that sets or clears the disable bit. It also writes the bit in the middle of an open window and pulses a second timeout partway through a window. A behavioural model advances the qualification count, the window length and the disable bit with integers on each edge. The bench compares `core_rst`, `pin_oe`, `pin_out` and `sfr_rdata` with this model after every edge, so any cycle in which the drive starts, stops or restarts at the wrong time is reported.

// File: rtl/reset_pin_ctrl.sv
module reset_pin_ctrl #(
  parameter int OSC_PER_MC = 12,
  parameter int QUAL_MC    = 2,
  parameter int DRIVE_LEN  = 96,
  parameter logic [7:0] AUX_ADDR = 8'h8E,
  parameter int DIS_BIT    = 3
) (
  input  logic       clk,
  input  logic       por_n,
  input  logic       pin_in,
  input  logic       wdt_timeout,
  input  logic       sfr_wr,
  input  logic [7:0] sfr_addr,
  input  logic [7:0] sfr_wdata,
  output logic [7:0] sfr_rdata,
  output logic       core_rst,
  output logic       pin_oe,
  output logic       pin_out
);
  localparam int QUAL_LEN = OSC_PER_MC * QUAL_MC;
  localparam int QW = $clog2(QUAL_LEN + 1);
  localparam int DW = $clog2(DRIVE_LEN + 1);

  logic [QW-1:0] qual_cnt;
  logic [DW-1:0] drv_cnt;
  logic          dis_q;
  logic          pin_qual;
  logic          drv_act;
  logic          aux_hit;

  assign pin_qual = (qual_cnt == QW'(QUAL_LEN));
  assign drv_act  = (drv_cnt != '0);
  assign aux_hit  = (sfr_addr == AUX_ADDR);

  always_ff @(posedge clk or negedge por_n) begin
    if (!por_n)       qual_cnt <= '0;
    else if (!pin_in) qual_cnt <= '0;
    else if (!pin_qual) qual_cnt <= qual_cnt + 1'b1;
  end

  always_ff @(posedge clk or negedge por_n) begin
    if (!por_n)           drv_cnt <= '0;
    else if (wdt_timeout) drv_cnt <= DW'(DRIVE_LEN);
    else if (drv_act)     drv_cnt <= drv_cnt - 1'b1;
  end

  always_ff @(posedge clk or negedge por_n) begin
    if (!por_n)                 dis_q <= 1'b0;
    else if (pin_qual)          dis_q <= 1'b0;
    else if (sfr_wr && aux_hit) dis_q <= sfr_wdata[DIS_BIT];
  end

  assign core_rst  = pin_qual | drv_act;
  assign pin_oe    = drv_act & ~dis_q;
  assign pin_out   = pin_oe;
  assign sfr_rdata = aux_hit ? (8'(dis_q) << DIS_BIT) : 8'h00;

  assert_qualify_R1: assert property (@(posedge clk) disable iff (!por_n)
    (qual_cnt == QW'(QUAL_LEN - 1) && pin_in) |=> core_rst);

  assert_low_clears_R2: assert property (@(posedge clk) disable iff (!por_n)
    (!pin_in && !wdt_timeout && drv_cnt <= DW'(1)) |=> !core_rst);

  assert_window_rst_R5: assert property (@(posedge clk) disable iff (!por_n)
    wdt_timeout |=> core_rst);

  assert_restart_R4: assert property (@(posedge clk) disable iff (!por_n)
    (wdt_timeout && !dis_q && !(sfr_wr && aux_hit) && !pin_qual) |=> pin_oe);

  assert_disable_R6: assert property (@(posedge clk) disable iff (!por_n)
    (dis_q && !pin_qual && !(sfr_wr && aux_hit)) |=> !pin_oe);

  assert_qual_clear_R9: assert property (@(posedge clk) disable iff (!por_n)
    pin_qual |=> (sfr_rdata[DIS_BIT] == 1'b0 || !aux_hit));
endmodule

// File: tb/reset_pin_ctrl_test.sv
module reset_pin_ctrl_test;
  logic clk = 0;
  logic por_n = 0;
  logic pin_in = 0;
  logic wdt_timeout = 0;
  logic sfr_wr = 0;
  logic [7:0] sfr_addr = 8'h00;
  logic [7:0] sfr_wdata = 8'h00;
  logic [7:0] sfr_rdata;
  logic core_rst, pin_oe, pin_out;

  int compared = 0;
  int mismatched = 0;
  bit done = 0;

  int m_q = 0;
  int m_d = 0;
  bit m_dis = 0;

  always #2 clk = ~clk;

  reset_pin_ctrl uut (
    .clk(clk), .por_n(por_n), .pin_in(pin_in), .wdt_timeout(wdt_timeout),
    .sfr_wr(sfr_wr), .sfr_addr(sfr_addr), .sfr_wdata(sfr_wdata),
    .sfr_rdata(sfr_rdata), .core_rst(core_rst), .pin_oe(pin_oe), .pin_out(pin_out)
  );

  always @(posedge clk or negedge por_n) begin
    if (!por_n) begin
      m_q = 0; m_d = 0; m_dis = 0;
    end else begin
      if (m_q == 24) m_dis = 0;
      else if (sfr_wr && sfr_addr == 8'h8E) m_dis = sfr_wdata[3];
      if (!pin_in) m_q = 0;
      else if (m_q < 24) m_q = m_q + 1;
      if (wdt_timeout) m_d = 96;
      else if (m_d > 0) m_d = m_d - 1;
    end
  end

  task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
    compared++;
    if (act !== exp) begin
      mismatched++;
      $display("FAIL %s at %0t: actual %h expected %h", req, $time, act, exp);
    end
  endtask

  // Reference comparison on every cycle, away from the active edge
  always @(negedge clk) begin
    if (!done) begin
      logic exp_rst, exp_oe;
      exp_rst = (m_q == 24) || (m_d > 0);
      exp_oe  = (m_d > 0) && !m_dis;
      check("R1 R2 R5 R10 core_rst", {7'd0, core_rst}, {7'd0, exp_rst});
      check("R3 R4 R6 R10 pin_oe", {7'd0, pin_oe}, {7'd0, exp_oe});
      check("R3 R6 pin_out", {7'd0, pin_out}, {7'd0, exp_oe});
      check("R7 R8 R9 sfr_rdata", sfr_rdata,
            (sfr_addr == 8'h8E) ? {4'd0, m_dis, 3'd0} : 8'h00);
    end
  end

  task automatic cyc(input int n);
    repeat (n) begin @(negedge clk); #1; end
  endtask

  task automatic wr(input logic [7:0] a, input logic [7:0] d);
    sfr_wr = 1; sfr_addr = a; sfr_wdata = d;
    cyc(1);
    sfr_wr = 0; sfr_wdata = 8'h00; sfr_addr = 8'h8E;
  endtask

  task automatic pulse_wdt();
    wdt_timeout = 1; cyc(1); wdt_timeout = 0;
  endtask

  task automatic summary();
    if (!done) begin
      done = 1;
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
      $finish;
    end
  endtask

  initial begin
    #(4 * 200000);
    mismatched++;
    $display("FAIL watchdog: actual hung expected finish");
    summary();
  end

  initial begin
    sfr_addr = 8'h8E;
    cyc(3);
    // R10: power-on state
    check("R10 core_rst at por", {7'd0, core_rst}, 8'd0);
    check("R10 rdata at por", sfr_rdata, 8'h00);
    por_n = 1;
    cyc(2);
    // R2: 23 high samples then low, no reset
    pin_in = 1; cyc(23); pin_in = 0; cyc(3);
    check("R2 glitch ignored", {7'd0, core_rst}, 8'd0);
    // R1: 30 high samples qualify
    pin_in = 1; cyc(24);
    check("R1 qualified", {7'd0, core_rst}, 8'd1);
    cyc(6); pin_in = 0; cyc(2);
    // R7 R8: only bit 3 of 8E stored
    wr(8'h8E, 8'hF7); check("R7 other bits ignored", sfr_rdata, 8'h00);
    wr(8'h8D, 8'h08); check("R7 other address ignored", sfr_rdata, 8'h00);
    // R3: plain window
    pulse_wdt(); cyc(100);
    // R4: restart mid window
    pulse_wdt(); cyc(50); pulse_wdt(); cyc(100);
    // R6: disabled drive, R5 reset still asserted
    wr(8'h8E, 8'h08); check("R8 read bit3", sfr_rdata, 8'h08);
    pulse_wdt(); cyc(10);
    check("R5 rst while disabled", {7'd0, core_rst}, 8'd1);
    check("R6 no drive while disabled", {7'd0, pin_oe}, 8'd0);
    wr(8'h8E, 8'h00); cyc(5);
    check("R6 drive after clear mid window", {7'd0, pin_oe}, 8'd1);
    cyc(90);
    // same-cycle timeout and write
    sfr_wr = 1; sfr_addr = 8'h8E; sfr_wdata = 8'h08; wdt_timeout = 1; cyc(1);
    sfr_wr = 0; wdt_timeout = 0; cyc(20);
    sfr_wr = 1; sfr_wdata = 8'h00; wdt_timeout = 1; cyc(1);
    sfr_wr = 0; wdt_timeout = 0; cyc(100);
    // R9: qualified pin reset clears the bit, window does not
    wr(8'h8E, 8'h08); pulse_wdt(); cyc(100);
    check("R9 window keeps bit", sfr_rdata, 8'h08);
    pin_in = 1; cyc(26);
    wr(8'h8E, 8'h08);
    check("R9 write ignored during pin reset", sfr_rdata, 8'h00);
    pin_in = 0; cyc(3);
    sfr_addr = 8'h10; cyc(2);
    check("R8 other address reads zero", sfr_rdata, 8'h00);
    summary();
  end
endmodule